// File: doc/BRIEF.md
# Character Page Memory Access Controller

This block sits between a host processor bus and a byte-wide character page store. The store holds several chapters, each made of character rows of 40 columns, plus a separate 40-byte buffer for a broadcast service packet. The host never presents a memory address directly. It writes a mode register that picks the chapter and optionally routes the packet row. It writes a row register and a column register. Then it moves character bytes through one data register. After each accepted data access the column advances, and the row advances when the column wraps.

After reset, a sequencer sweeps the whole store one byte per clock. It fills it with space characters, except one position in the first chapter, which receives the white-text attribute. Setting the clear bit of the mode register starts the same sweep with spaces only. While a sweep runs, data accesses are refused, but register writes still land. A read-only status byte passes three signal-condition inputs to the host. The contents of the eight general control registers are presented on a flat output bus for downstream logic.

Top module: `ttx_page_mem_ctrl`

## Requirements
- R1: After reset, the control registers 0 to 7 on `ctrl_regs_o` (register k in bits 8k+7..8k) read 0x00, except registers 5 and 6, which read 0x03.
- R2: After reset release, `busy_o` stays high for exactly DEPTH = 4*25*40+40 = 4040 cycles. Afterwards every byte reads 0x20, except chapter 0, row 0, column 7, which reads 0x07.
- R3: A data access (address 11) reaches the byte at the chapter in mode register (address 8) bits 1..0, the row in address 9 and the column in address 10. A register write takes effect for a data access in the following cycle.
- R4: Each accepted data access increments the column. From column 39 the column goes to 0 and the row increments.
- R5: From row 24, column 39, an accepted access moves to row 0, column 0 of the same chapter.
- R6: When mode bit 2 is 1 and the row register holds 23, data accesses use the 40-byte packet buffer, whatever the chapter. With mode bit 2 at 0, row 23 is an ordinary page row.
- R7: Writing mode bit 3 as 1 starts a sweep that sets every byte to 0x20, including the packet buffer and chapter 0, row 0, column 7. `busy_o` rises in the cycle after the write. The chapter and packet bits of the same write take effect. The bit is not stored, so no further sweep follows.
- R8: While `busy_o` is high, data writes are dropped and data reads return 0x00 with `bus_rvalid_o`. Neither advances the column or the row. Register writes are still accepted.
- R9: Bits not defined in a register are stored as zero. The kept-bit masks are register 0: 0x07, register 2: 0x3F, register 3: 0x1F, register 4: 0x03, and 0xFF for registers 1, 5, 6 and 7.
- R10: A read of address 12 returns `line60_i` in bit 7, `sync_ok_i` in bit 1, `sig_good_i` in bit 0, and zero in bits 6..2.
- R11: Each read strobe gives `bus_rvalid_o` high one cycle later, and write strobes give none. Reads of addresses 0 to 10 and 13 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the preset sweep |
| bus_cs_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Host register address |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rvalid_o is high |
| bus_rvalid_o | output | 1 | High one cycle after a read strobe |
| line60_i | input | 1 | 60 Hz field-rate flag for the status byte |
| sync_ok_i | input | 1 | Sync-present flag for the status byte |
| sig_good_i | input | 1 | Signal-quality flag for the status byte |
| busy_o | output | 1 | High while a preset or clear sweep runs |
| ctrl_regs_o | output | 64 | Control registers 0 to 7, register k in bits 8k+7..8k |

## Verification
The checker assumes that the host keeps the row register below 25 and the column register below 40. It also assumes that the host issues at most one strobe per cycle, with address and data stable alongside it. The wrap properties and the address map hold only under these assumptions. The bench sets every position through the row and column registers with in-range values. It reaches the wrap corners only by stepping from row 24, column 39 and from column 39. It drives each strobe for a single cycle between clock edges, so no out-of-range position or overlapping access ever reaches the block.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam logic [3:0] A_MODE = 4'd8;
  localparam logic [3:0] A_ROW  = 4'd9;
  localparam logic [3:0] A_COL  = 4'd10;
  localparam logic [3:0] A_DATA = 4'd11;
  localparam logic [3:0] A_STAT = 4'd12;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_WHITE = 8'h07;

  // bits kept on a register write; undefined bits store as zero
  function automatic logic [7:0] keep_mask(input logic [3:0] a);
    case (a)
      4'd0:    keep_mask = 8'h07;
      4'd2:    keep_mask = 8'h3F;
      4'd3:    keep_mask = 8'h1F;
      4'd4:    keep_mask = 8'h03;
      4'd8:    keep_mask = 8'h07;
      4'd9:    keep_mask = 8'h1F;
      4'd10:   keep_mask = 8'h3F;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/ttx_regfile.sv
module ttx_regfile
  import ttx_pkg::*;
#(
  parameter int CH_W  = 2,
  parameter int ROW_W = 5,
  parameter int COL_W = 6,
  parameter int ROWS  = 25,
  parameter int COLS  = 40,
  parameter int NCTRL = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               step_i,
  output logic [CH_W-1:0]    chap_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [COL_W-1:0]   col_o,
  output logic               pkt_sel_o,
  output logic               clear_req_o,
  output logic [NCTRL*8-1:0] ctrl_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [CH_W-1:0]  chap_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             pkt_q;

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    localparam logic [7:0] RST_VAL = (g == 5 || g == 6) ? 8'h03 : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else if (wr_en && wr_addr == 4'(g)) q <= wr_data & keep_mask(4'(g));
    end
    assign ctrl_o[g*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chap_q <= '0;
      pkt_q  <= 1'b0;
    end else if (wr_en && wr_addr == A_MODE) begin
      chap_q <= wr_data[CH_W-1:0];
      pkt_q  <= wr_data[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step_i) begin
      if (col_q >= COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q >= ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end else if (wr_en) begin
      if (wr_addr == A_ROW) row_q <= wr_data[ROW_W-1:0];
      if (wr_addr == A_COL) col_q <= wr_data[COL_W-1:0];
    end
  end

  assign clear_req_o = wr_en && (wr_addr == A_MODE) && wr_data[3];
  assign chap_o      = chap_q;
  assign row_o       = row_q;
  assign col_o       = col_q;
  assign pkt_sel_o   = pkt_q;
endmodule

// File: rtl/ttx_addr_map.sv
module ttx_addr_map #(
  parameter int CH_W    = 2,
  parameter int ROW_W   = 5,
  parameter int COL_W   = 6,
  parameter int ROWS    = 25,
  parameter int COLS    = 40,
  parameter int CHAPS   = 4,
  parameter int PKT_ROW = 23,
  parameter int AW      = 12
) (
  input  logic [CH_W-1:0]  chap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             pkt_sel_i,
  output logic [AW-1:0]    addr_o
);
  localparam int PKT_BASE = CHAPS * ROWS * COLS;

  int page_lin;
  logic pkt_hit;

  always_comb begin
    pkt_hit  = pkt_sel_i && (int'(row_i) == PKT_ROW);
    page_lin = (int'(chap_i) * ROWS + int'(row_i)) * COLS + int'(col_i);
    if (pkt_hit) addr_o = AW'(PKT_BASE + int'(col_i));
    else         addr_o = AW'(page_lin);
  end
endmodule

// File: rtl/ttx_sweeper.sv
module ttx_sweeper
  import ttx_pkg::*;
#(
  parameter int DEPTH    = 4040,
  parameter int AW       = 12,
  parameter int MARK_LIN = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] PTR_MARK = AW'(MARK_LIN);

  logic          run_q;
  logic          preset_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b1;
      preset_q <= 1'b1;
      ptr_q    <= '0;
    end else if (clear_i) begin
      run_q    <= 1'b1;
      preset_q <= 1'b0;
      ptr_q    <= '0;
    end else if (run_q) begin
      if (ptr_q == PTR_LAST) run_q <= 1'b0;
      else                   ptr_q <= ptr_q + 1'b1;
    end
  end

  assign busy_o = run_q;
  assign we_o   = run_q;
  assign addr_o = ptr_q;
  assign data_o = (preset_q && ptr_q == PTR_MARK) ? CH_WHITE : CH_SPACE;
endmodule

// File: rtl/ttx_page_ram.sv
module ttx_page_ram #(
  parameter int DEPTH = 4040,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ttx_page_mem_ctrl.sv
module ttx_page_mem_ctrl
  import ttx_pkg::*;
#(
  parameter int CHAPS   = 4,
  parameter int ROWS    = 25,
  parameter int COLS    = 40,
  parameter int PKT_ROW = 23,
  parameter int NCTRL   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_cs_i,
  input  logic               bus_we_i,
  input  logic [3:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               bus_rvalid_o,
  input  logic               line60_i,
  input  logic               sync_ok_i,
  input  logic               sig_good_i,
  output logic               busy_o,
  output logic [NCTRL*8-1:0] ctrl_regs_o
);
  localparam int CH_W  = (CHAPS > 1) ? $clog2(CHAPS) : 1;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int DEPTH = CHAPS * ROWS * COLS + COLS;
  localparam int AW    = $clog2(DEPTH);

  logic [CH_W-1:0]  cur_chap;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             pkt_sel;
  logic             clear_req;
  logic             step;
  logic             host_data;
  logic [AW-1:0]    map_addr;
  logic             sw_busy, sw_we;
  logic [AW-1:0]    sw_addr;
  logic [7:0]       sw_data;
  logic             ram_we, ram_re;
  logic [AW-1:0]    ram_waddr;
  logic [7:0]       ram_wdata, ram_q;
  logic             rvalid_q, rd_mem_q;
  logic [7:0]       rd_byte_q;
  logic [7:0]       status_byte;

  assign host_data = bus_cs_i && (bus_addr_i == A_DATA);
  assign step      = host_data && !sw_busy;

  ttx_regfile #(
    .CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ROWS(ROWS), .COLS(COLS), .NCTRL(NCTRL)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_cs_i && bus_we_i), .wr_addr(bus_addr_i), .wr_data(bus_wdata_i),
    .step_i(step),
    .chap_o(cur_chap), .row_o(cur_row), .col_o(cur_col),
    .pkt_sel_o(pkt_sel), .clear_req_o(clear_req), .ctrl_o(ctrl_regs_o)
  );

  ttx_addr_map #(
    .CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W), .ROWS(ROWS), .COLS(COLS),
    .CHAPS(CHAPS), .PKT_ROW(PKT_ROW), .AW(AW)
  ) u_map (
    .chap_i(cur_chap), .row_i(cur_row), .col_i(cur_col),
    .pkt_sel_i(pkt_sel), .addr_o(map_addr)
  );

  ttx_sweeper #(.DEPTH(DEPTH), .AW(AW), .MARK_LIN(7)) u_sweep (
    .clk(clk), .rst(rst), .clear_i(clear_req),
    .busy_o(sw_busy), .we_o(sw_we), .addr_o(sw_addr), .data_o(sw_data)
  );

  assign ram_we    = sw_we || (step && bus_we_i);
  assign ram_waddr = sw_we ? sw_addr : map_addr;
  assign ram_wdata = sw_we ? sw_data : bus_wdata_i;
  assign ram_re    = step && !bus_we_i;

  ttx_page_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(map_addr), .rdata(ram_q)
  );

  assign status_byte = {line60_i, 5'b00000, sync_ok_i, sig_good_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      rd_mem_q  <= 1'b0;
      rd_byte_q <= 8'h00;
    end else begin
      rvalid_q  <= bus_cs_i && !bus_we_i;
      rd_mem_q  <= ram_re;
      rd_byte_q <= (bus_cs_i && !bus_we_i && bus_addr_i == A_STAT) ? status_byte : 8'h00;
    end
  end

  assign bus_rdata_o  = rd_mem_q ? ram_q : rd_byte_q;
  assign bus_rvalid_o = rvalid_q;
  assign busy_o       = sw_busy;
endmodule

// File: rtl/ttx_page_mem_ctrl_chk.sv
module ttx_page_mem_ctrl_chk #(
  parameter int ROWS  = 25,
  parameter int COLS  = 40,
  parameter int ROW_W = 5,
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_cs_i,
  input logic             bus_we_i,
  input logic [3:0]       bus_addr_i,
  input logic [7:0]       bus_rdata_o,
  input logic             bus_rvalid_o,
  input logic             busy_o,
  input logic             step,
  input logic [ROW_W-1:0] cur_row,
  input logic [COL_W-1:0] cur_col
);
  p_rvalid_follows_read_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_i && !bus_we_i) |=> bus_rvalid_o);

  p_no_spurious_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_cs_i && !bus_we_i) |=> !bus_rvalid_o);

  p_reg_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_i && !bus_we_i && bus_addr_i < 4'd11) |=> bus_rdata_o == 8'h00);

  p_status_spare_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_i && !bus_we_i && bus_addr_i == 4'd12) |=> bus_rdata_o[6:2] == 5'b00000);

  p_busy_holds_position_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !(bus_cs_i && bus_we_i)) |=> ($stable(cur_col) && $stable(cur_row)));

  p_col_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (step && cur_col == COL_W'(COLS - 1)) |=> cur_col == '0);

  p_row_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (step && cur_col == COL_W'(COLS - 1) && cur_row == ROW_W'(ROWS - 1)) |=> cur_row == '0);
endmodule

bind ttx_page_mem_ctrl ttx_page_mem_ctrl_chk #(
  .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .bus_rvalid_o(bus_rvalid_o),
  .busy_o(busy_o), .step(step), .cur_row(cur_row), .cur_col(cur_col)
);

// File: tb/ttx_page_mem_ctrl_tb_top.sv
module ttx_page_mem_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 4 * 25 * 40 + 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        l60 = 1'b0, syn = 1'b0, sq = 1'b0;
  logic        busy;
  logic [63:0] ctrl;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ttx_page_mem_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_cs_i(cs), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .line60_i(l60), .sync_ok_i(syn), .sig_good_i(sq),
    .busy_o(busy), .ctrl_regs_o(ctrl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rdata; v = rvalid;
  endtask

  task automatic set_pos(input bit pkt, input int ch, input int row, input int col);
    wr(4'd8, {5'b0, pkt, 2'(ch)});
    wr(4'd9, 8'(row));
    wr(4'd10, 8'(col));
  endtask

  task automatic read_at(input bit pkt, input int ch, input int row, input int col,
                         input int exp, input string req);
    logic [7:0] d; logic v;
    set_pos(pkt, ch, row, col);
    rd(4'd11, d, v);
    chk(req, int'(d), exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_and_preset();
    int n; logic [7:0] d; logic v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 reg5", int'(ctrl[47:40]), 8'h03);
    chk("R1 reg6", int'(ctrl[55:48]), 8'h03);
    chk("R1 reg0", int'(ctrl[7:0]), 8'h00);
    chk("R1 reg7", int'(ctrl[63:56]), 8'h00);
    chk("R2 busy at release", int'(busy), 1);
    wait_idle(n);
    chk("R2 sweep length", n, DEPTH);
    set_pos(1'b0, 0, 0, 0);
    for (int c = 0; c < 10; c++) begin
      rd(4'd11, d, v);
      chk($sformatf("R2 R4 preset col %0d", c), int'(d), (c == 7) ? 8'h07 : 8'h20);
    end
    read_at(1'b0, 1, 0, 7, 8'h20, "R2 other chapter col7");
    read_at(1'b0, 3, 24, 39, 8'h20, "R2 last byte");
  endtask

  task automatic t_write_read();
    logic [7:0] d; logic v;
    set_pos(1'b0, 2, 10, 3);
    wr(4'd11, 8'h41); wr(4'd11, 8'h42); wr(4'd11, 8'h43);
    wr(4'd10, 8'd3);
    rd(4'd11, d, v); chk("R3 byte0", int'(d), 8'h41);
    rd(4'd11, d, v); chk("R3 R4 byte1", int'(d), 8'h42);
    rd(4'd11, d, v); chk("R3 R4 byte2", int'(d), 8'h43);
    read_at(1'b0, 1, 10, 3, 8'h20, "R3 chapter isolation");
  endtask

  task automatic t_col_wrap();
    set_pos(1'b0, 1, 5, 39);
    wr(4'd11, 8'h55); wr(4'd11, 8'h66);
    read_at(1'b0, 1, 5, 39, 8'h55, "R4 col39");
    read_at(1'b0, 1, 6, 0, 8'h66, "R4 next row col0");
  endtask

  task automatic t_row_wrap();
    set_pos(1'b0, 3, 24, 39);
    wr(4'd11, 8'h77); wr(4'd11, 8'h88);
    read_at(1'b0, 3, 24, 39, 8'h77, "R5 last position");
    read_at(1'b0, 3, 0, 0, 8'h88, "R5 wrap to row0");
    read_at(1'b0, 0, 0, 0, 8'h20, "R5 chapter kept");
  endtask

  task automatic t_packet();
    set_pos(1'b1, 0, 23, 0);
    wr(4'd11, 8'h31);
    read_at(1'b1, 3, 23, 0, 8'h31, "R6 packet any chapter");
    read_at(1'b0, 0, 23, 0, 8'h20, "R6 normal row23 ch0");
    read_at(1'b0, 3, 23, 0, 8'h20, "R6 normal row23 ch3");
    set_pos(1'b0, 2, 23, 5);
    wr(4'd11, 8'h5A);
    read_at(1'b1, 0, 23, 5, 8'h20, "R6 page write misses packet");
    read_at(1'b0, 2, 23, 5, 8'h5A, "R6 page row23 stored");
  endtask

  task automatic t_status_and_reads();
    logic [7:0] d; logic v;
    l60 = 1'b1; syn = 1'b0; sq = 1'b1;
    rd(4'd12, d, v);
    chk("R10 status a", int'(d), 8'h81);
    chk("R11 rvalid status", int'(v), 1);
    l60 = 1'b0; syn = 1'b1; sq = 1'b0;
    rd(4'd12, d, v);
    chk("R10 status b", int'(d), 8'h02);
    rd(4'd5, d, v);
    chk("R11 reg read zero", int'(d), 8'h00);
    chk("R11 rvalid reg read", int'(v), 1);
    rd(4'd14, d, v);
    chk("R11 unmapped read zero", int'(d), 8'h00);
    wr(4'd3, 8'h12);
    chk("R11 no rvalid on write", int'(rvalid), 0);
  endtask

  task automatic t_reserved();
    wr(4'd0, 8'hFF); chk("R9 reg0 mask", int'(ctrl[7:0]), 8'h07);
    wr(4'd2, 8'hFF); chk("R9 reg2 mask", int'(ctrl[23:16]), 8'h3F);
    wr(4'd3, 8'hFF); chk("R9 reg3 mask", int'(ctrl[31:24]), 8'h1F);
    wr(4'd4, 8'hFF); chk("R9 reg4 mask", int'(ctrl[39:32]), 8'h03);
    wr(4'd1, 8'hFF); chk("R9 reg1 full", int'(ctrl[15:8]), 8'hFF);
  endtask

  task automatic t_clear_busy();
    int n; logic [7:0] d; logic v;
    set_pos(1'b0, 2, 2, 5);
    wr(4'd8, 8'h09);
    chk("R7 busy after clear", int'(busy), 1);
    wr(4'd11, 8'h99);
    rd(4'd11, d, v);
    chk("R8 blocked read data", int'(d), 8'h00);
    chk("R8 blocked read valid", int'(v), 1);
    wr(4'd9, 8'd4);
    wait_idle(n);
    wr(4'd11, 8'hAB);
    wr(4'd3, 8'h00);
    chk("R7 no second sweep", int'(busy), 0);
    read_at(1'b0, 1, 4, 5, 8'hAB, "R7 R8 chapter, row and column after clear");
    read_at(1'b0, 1, 4, 6, 8'h20, "R8 no extra step");
    read_at(1'b0, 2, 10, 3, 8'h20, "R7 page cleared");
    read_at(1'b0, 0, 0, 7, 8'h20, "R7 marker cleared");
    read_at(1'b1, 0, 23, 0, 8'h20, "R7 packet cleared");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_and_preset();
    t_write_read();
    t_col_wrap();
    t_row_wrap();
    t_packet();
    t_status_and_reads();
    t_reserved();
    t_clear_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule